// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block is a memory-mapped slave. Through a small window of 64-bit registers it gives a host access to a separate space of 32-bit registers. The host writes a single command word. That word carries an opcode, a byte address and write data. The bridge turns it into one read or one write on a request/acknowledge back-end port. It then reports the outcome in a status word, which holds a completion flag, a sticky error flag and the captured read data.

The window also holds a read-only parameter word. Elaboration-time parameters fix its contents, and it describes the shared serial peripheral master that sits behind the bridge: shift order, word width, chip-select count, clock polarity, clock phase and a peripheral identifier. To finish an access, the host writes the command and then polls the status word until the completion flag is set.

Top module: `ind_reg_bridge`

## Requirements
- R1: The window decodes three 64-bit offsets: 0x08 is the parameter word, 0x10 is the command word and 0x18 is the status word. A host read returns data on `host_rdata` in the cycle after `host_rd_en`. Reads of the command offset or of any undecoded offset return zero. Host writes to any offset other than 0x10 have no effect.
- R2: The parameter word holds the following fields. Bit 1 is the shift order (1 = LSB first). Bits [7:2] are the word width. Bits [13:8] are the chip-select count. Bit 14 is clock polarity and bit 15 is clock phase. Bits [47:32] are the peripheral identifier. Every other bit reads 0.
- R3: The command word holds the opcode in bits [63:62], the byte address in bits [44:32] and the write data in bits [31:0]. Opcode 1 means read, 2 means write, and 0 or 3 means no-op. Registers sit on a 4-byte stride, so `be_addr` carries byte-address bits [12:2].
- R4: A read or write command written while the bridge is idle raises `be_req` in the next cycle. At the same time `be_wr` (1 = write), `be_addr` and `be_wdata` take their values from the command. All four are held unchanged until `be_ack` is sampled high.
- R5: A no-op command (opcode 0 or 3) starts no back-end access and leaves the status word unchanged.
- R6: At the clock edge where an accepted command is written, the completion flag (status bit 32) clears. The flag sets again at the edge where `be_ack` is sampled together with `be_req`, and `be_req` drops at that same edge.
- R7: A read completion captures `be_rdata` into status bits [31:0]. That value holds until the next command is accepted. A write completion leaves those bits at zero.
- R8: A read or write command written while an access is in flight is ignored. This includes the cycle in which the acknowledge arrives. Each ignored command sets a sticky error flag in status bit 33, and only reset clears it.
- R9: After reset, `be_req` is low, `host_rdata` is zero and the status word reads zero.
- R10: A `be_ack` pulse that arrives while no request is outstanding changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe |
| host_rd_en | input | 1 | Host read strobe |
| host_addr | input | HOST_AW | Host byte offset into the window |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Registered host read data |
| be_req | output | 1 | Back-end request, held until acknowledged |
| be_wr | output | 1 | Back-end direction, 1 = write |
| be_addr | output | IND_AW-2 | Back-end word address |
| be_wdata | output | IND_DW | Back-end write data |
| be_ack | input | 1 | Back-end acknowledge, one cycle |
| be_rdata | input | IND_DW | Back-end read data, valid with `be_ack` |

## Verification
A new command from the host can land in the same cycle as the back-end acknowledge of the access it would replace. The bench provokes this by driving `be_ack` with chosen read data on the same edge as a write command. The expected outcome has three parts: the command is ignored with no second request raised, the first read completes with the acknowledged data, and the error flag sets. A long-latency access is also overrun by a second command, and the test then confirms that the back-end address, the direction and the untouched target register all stay as they were.

// File: rtl/ibr_pkg.sv
package ibr_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2,
    CMD_RSV = 2'd3
  } ibr_cmd_e;

  localparam int WIN_W         = 64;
  localparam int OFS_PARAM     = 'h08;
  localparam int OFS_CTRL      = 'h10;
  localparam int OFS_STAT      = 'h18;
  localparam int CTRL_ADDR_LSB = 32;
  localparam int CTRL_CMD_LSB  = 62;
  localparam int STAT_VLD_BIT  = 32;
  localparam int STAT_ERR_BIT  = 33;

  // Assemble the read-only description word of the serial master.
  function automatic logic [WIN_W-1:0] make_param(
    input logic        lsb_first,
    input logic [5:0]  width,
    input logic [5:0]  num_cs,
    input logic        cpol,
    input logic        cpha,
    input logic [15:0] pid
  );
    logic [WIN_W-1:0] w;
    w        = '0;
    w[1]     = lsb_first;
    w[7:2]   = width;
    w[13:8]  = num_cs;
    w[14]    = cpol;
    w[15]    = cpha;
    w[47:32] = pid;
    return w;
  endfunction

endpackage

// File: rtl/ibr_decode.sv
module ibr_decode #(
  parameter int HOST_AW = 5
) (
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [HOST_AW-1:0] addr,
  output logic               ctrl_wr,
  output logic               rd_param,
  output logic               rd_stat
);
  import ibr_pkg::*;

  localparam logic [HOST_AW-1:0] A_PARAM = HOST_AW'(OFS_PARAM);
  localparam logic [HOST_AW-1:0] A_CTRL  = HOST_AW'(OFS_CTRL);
  localparam logic [HOST_AW-1:0] A_STAT  = HOST_AW'(OFS_STAT);

  always_comb begin
    ctrl_wr  = wr_en && (addr == A_CTRL);
    rd_param = rd_en && (addr == A_PARAM);
    rd_stat  = rd_en && (addr == A_STAT);
  end
endmodule

// File: rtl/ibr_launch.sv
module ibr_launch #(
  parameter int IND_AW = 13,
  parameter int IND_DW = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ctrl_wr,
  input  ibr_pkg::ibr_cmd_e   cmd,
  input  logic [IND_AW-1:0]   cmd_addr,
  input  logic [IND_DW-1:0]   cmd_data,
  input  logic                be_ack,
  output logic                be_req,
  output logic                be_wr,
  output logic [IND_AW-3:0]   be_addr,
  output logic [IND_DW-1:0]   be_wdata,
  output logic                accept,
  output logic                reject,
  output logic                done,
  output logic                done_rd
);
  import ibr_pkg::*;

  localparam int WORD_AW = IND_AW - 2;

  logic is_access;
  logic unused_byte_lsb;

  assign unused_byte_lsb = ^cmd_addr[1:0];

  always_comb begin
    is_access = (cmd == CMD_RD) || (cmd == CMD_WR);
    accept    = ctrl_wr && is_access && !be_req;
    reject    = ctrl_wr && is_access && be_req;
    done      = be_req && be_ack;
    done_rd   = done && !be_wr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      be_req   <= 1'b0;
      be_wr    <= 1'b0;
      be_addr  <= '0;
      be_wdata <= '0;
    end else if (done) begin
      be_req <= 1'b0;
    end else if (accept) begin
      be_req   <= 1'b1;
      be_wr    <= (cmd == CMD_WR);
      be_addr  <= cmd_addr[IND_AW-1 -: WORD_AW];
      be_wdata <= cmd_data;
    end
  end
endmodule

// File: rtl/ibr_status.sv
module ibr_status #(
  parameter int IND_DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              reject,
  input  logic              done,
  input  logic              done_rd,
  input  logic [IND_DW-1:0] be_rdata,
  output logic              valid,
  output logic              err,
  output logic [IND_DW-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      err   <= 1'b0;
      rdata <= '0;
    end else begin
      if (accept) begin
        valid <= 1'b0;
        rdata <= '0;
      end else if (done) begin
        valid <= 1'b1;
        if (done_rd) rdata <= be_rdata;
      end
      if (reject) err <= 1'b1;
    end
  end
endmodule

// File: rtl/ibr_readmux.sv
module ibr_readmux #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_en,
  input  logic         rd_param,
  input  logic         rd_stat,
  input  logic [W-1:0] param_word,
  input  logic [W-1:0] stat_word,
  output logic [W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (rd_param)     rdata <= param_word;
      else if (rd_stat) rdata <= stat_word;
      else              rdata <= '0;
    end
  end
endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge #(
  parameter int          HOST_AW         = 5,
  parameter int          IND_AW          = 13,
  parameter int          IND_DW          = 32,
  parameter bit          SHIFT_LSB_FIRST = 1'b0,
  parameter int          SPI_WORD_W      = 32,
  parameter int          SPI_NUM_CS      = 1,
  parameter bit          SPI_CPOL        = 1'b0,
  parameter bit          SPI_CPHA        = 1'b0,
  parameter logic [15:0] PERIPH_ID       = 16'h0001
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_wr_en,
  input  logic               host_rd_en,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [63:0]        host_wdata,
  output logic [63:0]        host_rdata,
  output logic               be_req,
  output logic               be_wr,
  output logic [IND_AW-3:0]  be_addr,
  output logic [IND_DW-1:0]  be_wdata,
  input  logic               be_ack,
  input  logic [IND_DW-1:0]  be_rdata
);
  import ibr_pkg::*;

  localparam logic [WIN_W-1:0] PARAM_WORD = make_param(
    SHIFT_LSB_FIRST, 6'(SPI_WORD_W), 6'(SPI_NUM_CS), SPI_CPOL, SPI_CPHA, PERIPH_ID);

  logic              ctrl_wr, rd_param, rd_stat;
  logic              accept, reject, done, done_rd;
  logic              st_valid, st_err;
  logic [IND_DW-1:0] st_rdata;
  logic [WIN_W-1:0]  stat_word;
  ibr_cmd_e          cmd;
  logic              unused_rsvd;

  assign cmd         = ibr_cmd_e'(host_wdata[CTRL_CMD_LSB +: 2]);
  assign unused_rsvd = ^host_wdata[CTRL_CMD_LSB-1:CTRL_ADDR_LSB+IND_AW];

  always_comb begin
    stat_word               = '0;
    stat_word[IND_DW-1:0]   = st_rdata;
    stat_word[STAT_VLD_BIT] = st_valid;
    stat_word[STAT_ERR_BIT] = st_err;
  end

  ibr_decode #(.HOST_AW(HOST_AW)) u_dec (
    .wr_en   (host_wr_en),
    .rd_en   (host_rd_en),
    .addr    (host_addr),
    .ctrl_wr (ctrl_wr),
    .rd_param(rd_param),
    .rd_stat (rd_stat)
  );

  ibr_launch #(.IND_AW(IND_AW), .IND_DW(IND_DW)) u_launch (
    .clk     (clk),
    .rst     (rst),
    .ctrl_wr (ctrl_wr),
    .cmd     (cmd),
    .cmd_addr(host_wdata[CTRL_ADDR_LSB +: IND_AW]),
    .cmd_data(host_wdata[IND_DW-1:0]),
    .be_ack  (be_ack),
    .be_req  (be_req),
    .be_wr   (be_wr),
    .be_addr (be_addr),
    .be_wdata(be_wdata),
    .accept  (accept),
    .reject  (reject),
    .done    (done),
    .done_rd (done_rd)
  );

  ibr_status #(.IND_DW(IND_DW)) u_stat (
    .clk     (clk),
    .rst     (rst),
    .accept  (accept),
    .reject  (reject),
    .done    (done),
    .done_rd (done_rd),
    .be_rdata(be_rdata),
    .valid   (st_valid),
    .err     (st_err),
    .rdata   (st_rdata)
  );

  ibr_readmux #(.W(WIN_W)) u_rmux (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (host_rd_en),
    .rd_param  (rd_param),
    .rd_stat   (rd_stat),
    .param_word(PARAM_WORD),
    .stat_word (stat_word),
    .rdata     (host_rdata)
  );
endmodule

// File: rtl/ibr_checker.sv
module ibr_checker #(
  parameter int HOST_AW = 5,
  parameter int BE_AW   = 11
) (
  input logic               clk,
  input logic               rst,
  input logic               host_wr_en,
  input logic [HOST_AW-1:0] host_addr,
  input logic [63:0]        host_wdata,
  input logic               be_req,
  input logic               be_ack,
  input logic               be_wr,
  input logic [BE_AW-1:0]   be_addr,
  input logic               stat_valid,
  input logic               stat_err
);
  import ibr_pkg::*;

  logic cmd_access;
  assign cmd_access = host_wr_en && (host_addr == HOST_AW'(OFS_CTRL)) &&
                      (host_wdata[63:62] == 2'd1 || host_wdata[63:62] == 2'd2);

  a_r4_launch: assert property (@(posedge clk) disable iff (rst)
    (cmd_access && !be_req) |=> be_req);

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (be_req && !be_ack) |=> (be_req && $stable(be_addr) && $stable(be_wr)));

  a_r5_no_spurious_req: assert property (@(posedge clk) disable iff (rst)
    (!be_req && !cmd_access) |=> !be_req);

  a_r6_clear_on_launch: assert property (@(posedge clk) disable iff (rst)
    (cmd_access && !be_req) |=> !stat_valid);

  a_r6_set_on_ack: assert property (@(posedge clk) disable iff (rst)
    (be_req && be_ack) |=> (!be_req && stat_valid));

  a_r8_flag_reject: assert property (@(posedge clk) disable iff (rst)
    (cmd_access && be_req) |=> stat_err);

  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    stat_err |=> stat_err);

  a_r9_reset_state: assert property (@(posedge clk)
    rst |=> (!be_req && !stat_valid && !stat_err));
endmodule

bind ind_reg_bridge ibr_checker #(.HOST_AW(HOST_AW), .BE_AW(IND_AW-2)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .host_wr_en(host_wr_en),
  .host_addr (host_addr),
  .host_wdata(host_wdata),
  .be_req    (be_req),
  .be_ack    (be_ack),
  .be_wr     (be_wr),
  .be_addr   (be_addr),
  .stat_valid(st_valid),
  .stat_err  (st_err)
);

// File: tb/ind_reg_bridge_test.sv
`timescale 1ns/1ps
module ind_reg_bridge_test;
  localparam int HOST_AW = 5;
  localparam logic [4:0] O_PARAM = 5'h08, O_CTRL = 5'h10, O_STAT = 5'h18;

  logic        clk = 1'b0;
  logic        rst;
  logic        host_wr_en, host_rd_en;
  logic [4:0]  host_addr;
  logic [63:0] host_wdata, host_rdata;
  logic        be_req, be_wr, be_ack;
  logic [10:0] be_addr;
  logic [31:0] be_wdata, be_rdata;

  logic        auto_mode = 1'b1;
  logic        auto_ack = 1'b0, man_ack = 1'b0;
  logic [31:0] auto_rdata = '0, man_rdata = '0;
  int          lat = 1;
  int          cnt = 0;
  logic [31:0] mem [16];

  int  errors = 0, checks = 0;
  bit  finished = 0;
  logic [63:0] st;

  always #2.5 clk = ~clk;

  assign be_ack   = auto_mode ? auto_ack : man_ack;
  assign be_rdata = auto_mode ? auto_rdata : man_rdata;

  ind_reg_bridge #(
    .HOST_AW(HOST_AW), .IND_AW(13), .IND_DW(32),
    .SHIFT_LSB_FIRST(1'b1), .SPI_WORD_W(16), .SPI_NUM_CS(3),
    .SPI_CPOL(1'b1), .SPI_CPHA(1'b0), .PERIPH_ID(16'hA5C3)
  ) uut (
    .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .be_req(be_req), .be_wr(be_wr), .be_addr(be_addr), .be_wdata(be_wdata),
    .be_ack(be_ack), .be_rdata(be_rdata)
  );

  // Back-end model: acknowledges after lat cycles of request.
  always @(negedge clk) begin
    if (!auto_mode) begin
      auto_ack <= 1'b0;
      cnt      <= 0;
    end else if (auto_ack) begin
      auto_ack <= 1'b0;
      cnt      <= 0;
    end else if (be_req) begin
      if (cnt >= lat) begin
        auto_ack <= 1'b1;
        if (be_wr) mem[be_addr[3:0]] <= be_wdata;
        else       auto_rdata <= mem[be_addr[3:0]];
      end else begin
        cnt <= cnt + 1;
      end
    end
  end

  function automatic logic [63:0] mk_cmd(input logic [1:0] op, input logic [12:0] a,
                                         input logic [31:0] d);
    return {op, 17'd0, a, d};
  endfunction

  function automatic logic [63:0] mk_stat(input logic v, input logic e, input logic [31:0] d);
    return {30'd0, e, v, d};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [4:0] a, input logic [63:0] d);
    host_wr_en = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic host_read(input logic [4:0] a, output logic [63:0] d);
    host_rd_en = 1'b1; host_addr = a;
    @(negedge clk);
    d = host_rdata;
    host_rd_en = 1'b0;
  endtask

  task automatic poll(output logic [63:0] d);
    for (int i = 0; i < 60; i++) begin
      host_read(O_STAT, d);
      if (d[32]) break;
    end
  endtask

  task automatic t_reset;
    logic [63:0] d;
    check("R9 host_rdata after reset", host_rdata, 64'd0);
    check("R9 be_req after reset", {63'd0, be_req}, 64'd0);
    host_read(O_STAT, d);
    check("R9 status after reset", d, 64'd0);
    host_read(5'h00, d);
    check("R1 undecoded offset reads zero", d, 64'd0);
  endtask

  task automatic t_param;
    logic [63:0] d, exp;
    exp = (64'd1 << 1) | (64'd16 << 2) | (64'd3 << 8) | (64'd1 << 14) | (64'hA5C3 << 32);
    host_read(O_PARAM, d);
    check("R2 parameter word", d, exp);
  endtask

  task automatic t_write_then_read;
    logic [63:0] d;
    lat = 3;
    host_write(O_CTRL, mk_cmd(2'd2, 13'h0044, 32'hDEADBEEF));
    check("R4 req after write cmd", {63'd0, be_req}, 64'd1);
    check("R4 be_wr for write", {63'd0, be_wr}, 64'd1);
    check("R3 word address stride", {53'd0, be_addr}, 64'h11);
    check("R4 write data", {32'd0, be_wdata}, 64'hDEADBEEF);
    host_read(O_STAT, d);
    check("R6 valid low while in flight", d, mk_stat(1'b0, 1'b0, 32'd0));
    poll(d);
    check("R7 write completion reads zero", d, mk_stat(1'b1, 1'b0, 32'd0));
    host_write(O_CTRL, mk_cmd(2'd1, 13'h0044, 32'h0));
    check("R4 be_wr low for read", {63'd0, be_wr}, 64'd0);
    poll(d);
    check("R7 read data captured", d, mk_stat(1'b1, 1'b0, 32'hDEADBEEF));
  endtask

  task automatic t_nop;
    logic [63:0] d;
    host_write(O_CTRL, mk_cmd(2'd0, 13'h0008, 32'h1111));
    check("R5 nop raises no req", {63'd0, be_req}, 64'd0);
    host_write(O_CTRL, mk_cmd(2'd3, 13'h0008, 32'h2222));
    check("R5 opcode 3 raises no req", {63'd0, be_req}, 64'd0);
    host_read(O_STAT, d);
    check("R5 R7 status held after nops", d, mk_stat(1'b1, 1'b0, 32'hDEADBEEF));
  endtask

  task automatic t_other_writes;
    logic [63:0] d;
    host_write(O_STAT, '1);
    host_write(O_PARAM, '1);
    check("R1 non-command write raises no req", {63'd0, be_req}, 64'd0);
    host_read(O_STAT, d);
    check("R1 status unaffected by write", d, mk_stat(1'b1, 1'b0, 32'hDEADBEEF));
    host_read(O_PARAM, d);
    check("R1 parameter unaffected by write", d,
          (64'd1 << 1) | (64'd16 << 2) | (64'd3 << 8) | (64'd1 << 14) | (64'hA5C3 << 32));
    host_read(O_CTRL, d);
    check("R1 command offset reads zero", d, 64'd0);
  endtask

  task automatic t_stray_ack;
    logic [63:0] d;
    auto_mode = 1'b0;
    man_rdata = 32'hBAD0BAD0; man_ack = 1'b1;
    @(negedge clk);
    man_ack = 1'b0;
    check("R10 stray ack raises no req", {63'd0, be_req}, 64'd0);
    host_read(O_STAT, d);
    check("R10 stray ack leaves status", d, mk_stat(1'b1, 1'b0, 32'hDEADBEEF));
  endtask

  task automatic t_collide;
    logic [63:0] d;
    auto_mode = 1'b0;
    host_write(O_CTRL, mk_cmd(2'd1, 13'h0050, 32'h0));
    check("R4 req raised for collide read", {63'd0, be_req}, 64'd1);
    man_rdata = 32'h12345678; man_ack = 1'b1;
    host_wr_en = 1'b1; host_addr = O_CTRL; host_wdata = mk_cmd(2'd2, 13'h0054, 32'h99);
    @(negedge clk);
    man_ack = 1'b0; host_wr_en = 1'b0;
    check("R8 command in ack cycle ignored", {63'd0, be_req}, 64'd0);
    repeat (3) @(negedge clk);
    check("R8 no late launch", {63'd0, be_req}, 64'd0);
    host_read(O_STAT, d);
    check("R8 R6 R7 collide status", d, mk_stat(1'b1, 1'b1, 32'h12345678));
    auto_mode = 1'b1;
  endtask

  task automatic t_busy;
    logic [63:0] d;
    lat = 20;
    host_write(O_CTRL, mk_cmd(2'd1, 13'h0048, 32'h0));
    host_write(O_CTRL, mk_cmd(2'd2, 13'h004C, 32'h55));
    check("R8 address kept while busy", {53'd0, be_addr}, 64'h12);
    check("R8 direction kept while busy", {63'd0, be_wr}, 64'd0);
    host_read(O_STAT, d);
    check("R6 R7 in flight status cleared", d, mk_stat(1'b0, 1'b1, 32'd0));
    poll(d);
    check("R8 first access completes", d, mk_stat(1'b1, 1'b1, 32'hA0000002));
    lat = 1;
    host_write(O_CTRL, mk_cmd(2'd1, 13'h004C, 32'h0));
    poll(d);
    check("R8 ignored write had no effect, flag sticky", d, mk_stat(1'b1, 1'b1, 32'hA0000003));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'hA0000000 + i;
    rst = 1'b1; host_wr_en = 1'b0; host_rd_en = 1'b0;
    host_addr = '0; host_wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_param();
    t_write_then_read();
    t_nop();
    t_other_writes();
    t_stray_ack();
    t_collide();
    t_busy();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule